// File: doc/BRIEF.md
# Interrupt Vector Ring Consumer

This block drains a circular ring of interrupt vectors that a producer writes into memory. When woken by a kick, it fetches the producer's write-pointer word and reads each 16-byte entry between its own read pointer and that write pointer. It extracts the fields of every entry and hands the result downstream on a valid/ready stream. Page-fault vectors that carry a nonzero address-space ID go through a request/grant credit check first. A fault vector whose credit is refused is dropped without being presented.

Once the pointers meet, the block publishes its read pointer so the producer can reuse the space. It then fetches the write pointer one more time to pick up entries that arrived late, and goes idle only if that fetch finds nothing new. If the producer reports that it overran the ring, the block clears the flag, jumps past the oldest overwritten slot and pulses a clear strobe back to the producer. The publish path is chosen by a parameter: either a doorbell strobe paired with a shadow-memory strobe, or a plain register strobe.

Top module: `ivring_consumer`

## Requirements
- R1: Every forwarded vector presents source ID = word0[7:0], source data = word1[27:0], ring ID = word2[7:0], VMID = word2[15:8], address-space ID = word2[31:16], and a client ID that is always 0.
- R2: Pointers count bytes. Entry words are fetched from word index (read pointer >> 2), +1 and +2 (word 3 is never read), and the memory returns data one cycle after each request.
- R3: A credit request, carrying the vector's address-space ID, is raised exactly for vectors whose source ID is 146 or 147 and whose address-space ID is nonzero.
- R4: A vector that is not a fault, or is a fault with address-space ID 0, or is a fault whose credit is granted, is forwarded. A fault whose credit is refused is never presented.
- R5: The read pointer advances by 16 bytes, modulo the ring size, for every entry, whether it is forwarded or dropped.
- R6: When the read pointer equals the write pointer, the read pointer is published once and the write pointer is fetched again. New entries found by that fetch are drained and published. Otherwise the block goes idle.
- R7: If bit 0 of the write-pointer word is set, that bit is cleared, the read pointer becomes (write pointer + 16) modulo the ring size, and a one-cycle overflow-clear strobe is issued.
- R8: In doorbell mode (default) each publish raises the doorbell and shadow strobes together in the same cycle and never the register strobe. The published value is the read pointer.
- R9: While a vector is valid and not accepted, it stays valid with every field unchanged.
- R10: A credit request stays high with a stable address-space ID until it is acknowledged, and it may wait any number of cycles.
- R11: During and just after reset, all strobes (valid, credit request, memory read, publish, overflow clear) are low.
- R12: Write-pointer bits at and above log2(ring bytes) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Wake-up pulse; new vectors may exist |
| wptr_word | input | 32 | Producer write-pointer word; bit 0 flags overflow |
| ovf_clr | output | 1 | One-cycle overflow-clear strobe to producer |
| mem_rd_en | output | 1 | Ring word read request |
| mem_rd_addr | output | BW-2 (6) | Ring word index |
| mem_rd_data | input | 32 | Ring word, one cycle after request |
| credit_req | output | 1 | Fault credit request, held until acknowledged |
| credit_pasid | output | 16 | Address-space ID under check |
| credit_ack | input | 1 | Credit answer strobe |
| credit_ok | input | 1 | Credit granted, qualified by credit_ack |
| iv_valid | output | 1 | Decoded vector valid |
| iv_ready | input | 1 | Downstream accepts vector |
| iv_client | output | 8 | Client ID, constant 0 |
| iv_src_id | output | 8 | Source ID |
| iv_src_data | output | 28 | Source data |
| iv_ring_id | output | 8 | Ring ID |
| iv_vmid | output | 8 | VMID |
| iv_pasid | output | 16 | Address-space ID |
| db_wr | output | 1 | Doorbell publish strobe |
| shadow_wr | output | 1 | Shadow-memory publish strobe |
| reg_wr | output | 1 | Register publish strobe |
| rptr_out | output | 32 | Published read pointer (bytes) |

## Verification
On every cycle, the assertions check that a stalled vector and a pending credit request hold steady. They also check that each accepted entry moves the read pointer by exactly 16, that an overflow jump lands 16 bytes past the stripped write pointer, and that nothing is presented while the ring is empty. Other behaviour shows up only across whole scenarios: which fault vectors are dropped under refused credit, the late-entry refetch that yields a second publish, the wrap past the top of the ring, the recovery after a full-ring overrun, and the final pointer value after long credit stalls.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int ENTRY_BYTES = 16;
  localparam logic [7:0] FAULT_SRC_LO = 8'd146;
  localparam logic [7:0] FAULT_SRC_HI = 8'd147;
  localparam logic [7:0] LEGACY_CLIENT = 8'd0;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_READ, S_DECIDE, S_CRED, S_EMIT, S_PUB
  } ivr_state_t;

  typedef struct packed {
    logic [7:0]  client;
    logic [7:0]  src_id;
    logic [27:0] src_data;
    logic [7:0]  ring_id;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } iv_fields_t;
endpackage

// File: rtl/ivr_gather.sv
module ivr_gather #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic [31:0]   w0,
  output logic [31:0]   w1,
  output logic [31:0]   w2,
  output logic          done
);
  logic       issuing;
  logic [1:0] cnt;
  logic       cap_v;
  logic [1:0] cap_i;

  assign rd_en   = issuing;
  assign rd_addr = base + AW'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing <= 1'b0;
      cnt     <= 2'd0;
      cap_v   <= 1'b0;
      cap_i   <= 2'd0;
      done    <= 1'b0;
    end else begin
      done  <= 1'b0;
      cap_v <= issuing;
      cap_i <= cnt;
      if (start) begin
        issuing <= 1'b1;
        cnt     <= 2'd0;
      end else if (issuing) begin
        if (cnt == 2'd2) issuing <= 1'b0;
        else             cnt <= cnt + 2'd1;
      end
      if (cap_v && cap_i == 2'd2) done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_v) begin
      case (cap_i)
        2'd0:    w0 <= rd_data;
        2'd1:    w1 <= rd_data;
        default: w2 <= rd_data;
      endcase
    end
  end

  // R2: reads come in one burst of three consecutive word indexes
  a_r2_burst: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en) && !start) |-> rd_addr == $past(rd_addr) + AW'(1));
endmodule

// File: rtl/ivr_decode.sv
module ivr_decode import ivr_pkg::*; (
  input  logic [31:0] w0,
  input  logic [31:0] w1,
  input  logic [31:0] w2,
  output iv_fields_t  fld,
  output logic        is_fault,
  output logic        need_credit
);
  always_comb begin
    fld.client   = LEGACY_CLIENT;
    fld.src_id   = w0[7:0];
    fld.src_data = w1[27:0];
    fld.ring_id  = w2[7:0];
    fld.vmid     = w2[15:8];
    fld.pasid    = w2[31:16];
  end

  assign is_fault    = (fld.src_id == FAULT_SRC_LO) || (fld.src_id == FAULT_SRC_HI);
  assign need_credit = is_fault && (fld.pasid != 16'd0);
endmodule

// File: rtl/ivr_publish.sv
module ivr_publish #(
  parameter int BW = 8,
  parameter bit USE_DOORBELL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [BW-1:0] val,
  output logic          db_wr,
  output logic          shadow_wr,
  output logic          reg_wr,
  output logic [31:0]   ptr_out
);
  always_ff @(posedge clk) begin
    if (rst)     ptr_out <= 32'd0;
    else if (go) ptr_out <= 32'(val);
  end

  generate
    if (USE_DOORBELL) begin : g_doorbell
      logic db_q;
      always_ff @(posedge clk) begin
        if (rst) db_q <= 1'b0;
        else     db_q <= go;
      end
      assign db_wr     = db_q;
      assign shadow_wr = db_q;
      assign reg_wr    = 1'b0;
    end else begin : g_register
      logic rg_q;
      always_ff @(posedge clk) begin
        if (rst) rg_q <= 1'b0;
        else     rg_q <= go;
      end
      assign db_wr     = 1'b0;
      assign shadow_wr = 1'b0;
      assign reg_wr    = rg_q;
    end
  endgenerate

  // R8: the published value is the pointer captured on the request
  a_r8_value: assert property (@(posedge clk) disable iff (rst)
    go |=> ptr_out == 32'($past(val)));
  a_r8_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && db_wr));
endmodule

// File: rtl/ivring_consumer.sv
module ivring_consumer import ivr_pkg::*; #(
  parameter int RING_BYTES = 256,
  parameter bit USE_DOORBELL = 1'b1,
  localparam int BW = $clog2(RING_BYTES),
  localparam int AW = BW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kick,
  input  logic [31:0]   wptr_word,
  output logic          ovf_clr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          credit_req,
  output logic [15:0]   credit_pasid,
  input  logic          credit_ack,
  input  logic          credit_ok,
  output logic          iv_valid,
  input  logic          iv_ready,
  output logic [7:0]    iv_client,
  output logic [7:0]    iv_src_id,
  output logic [27:0]   iv_src_data,
  output logic [7:0]    iv_ring_id,
  output logic [7:0]    iv_vmid,
  output logic [15:0]   iv_pasid,
  output logic          db_wr,
  output logic          shadow_wr,
  output logic          reg_wr,
  output logic [31:0]   rptr_out
);
  localparam logic [BW-1:0] STEP = BW'(ENTRY_BYTES);

  ivr_state_t    state;
  logic [BW-1:0] rptr, wp, wp_strip;
  logic          again;
  logic [31:0]   w0, w1, w2;
  logic          gather_done, gather_start;
  iv_fields_t    fld;
  logic          is_fault, need_credit;

  // R7/R12: flag bit removed, pointer reduced to ring size
  assign wp_strip     = {wptr_word[BW-1:1], 1'b0};
  assign gather_start = (state == S_CHECK) && (rptr != wp);

  ivr_gather #(.AW(AW)) u_gather (
    .clk(clk), .rst(rst), .start(gather_start), .base(rptr[BW-1:2]),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
    .w0(w0), .w1(w1), .w2(w2), .done(gather_done)
  );

  ivr_decode u_decode (
    .w0(w0), .w1(w1), .w2(w2), .fld(fld),
    .is_fault(is_fault), .need_credit(need_credit)
  );

  ivr_publish #(.BW(BW), .USE_DOORBELL(USE_DOORBELL)) u_publish (
    .clk(clk), .rst(rst), .go(state == S_PUB), .val(rptr),
    .db_wr(db_wr), .shadow_wr(shadow_wr), .reg_wr(reg_wr), .ptr_out(rptr_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      rptr    <= '0;
      wp      <= '0;
      again   <= 1'b0;
      ovf_clr <= 1'b0;
    end else begin
      ovf_clr <= 1'b0;
      case (state)
        S_IDLE: if (kick) begin
          state <= S_FETCH;
          again <= 1'b0;
        end
        S_FETCH: begin
          wp <= wp_strip;
          if (wptr_word[0]) begin
            rptr    <= wp_strip + STEP;
            ovf_clr <= 1'b1;
          end
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (rptr == wp) state <= again ? S_IDLE : S_PUB;
          else begin
            again <= 1'b0;
            state <= S_READ;
          end
        end
        S_READ:   if (gather_done) state <= S_DECIDE;
        S_DECIDE: state <= need_credit ? S_CRED : S_EMIT;
        S_CRED: if (credit_ack) begin
          if (credit_ok) state <= S_EMIT;
          else begin
            rptr  <= rptr + STEP;
            state <= S_CHECK;
          end
        end
        S_EMIT: if (iv_ready) begin
          rptr  <= rptr + STEP;
          state <= S_CHECK;
        end
        default: begin
          again <= 1'b1;
          state <= S_FETCH;
        end
      endcase
    end
  end

  assign credit_req   = (state == S_CRED);
  assign credit_pasid = fld.pasid;
  assign iv_valid     = (state == S_EMIT);
  assign iv_client    = fld.client;
  assign iv_src_id    = fld.src_id;
  assign iv_src_data  = fld.src_data;
  assign iv_ring_id   = fld.ring_id;
  assign iv_vmid      = fld.vmid;
  assign iv_pasid     = fld.pasid;

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (iv_valid && !iv_ready) |=> iv_valid && $stable(fld));
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (credit_req && !credit_ack) |=> credit_req && $stable(credit_pasid));
  a_r3_req_fault: assert property (@(posedge clk) disable iff (rst)
    credit_req |-> is_fault && credit_pasid != 16'd0);
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (iv_valid && iv_ready) |=> rptr == BW'($past(rptr) + STEP));
  a_r7_ovf_jump: assert property (@(posedge clk) disable iff (rst)
    ovf_clr |-> rptr == BW'({$past(wptr_word[BW-1:1]), 1'b0} + STEP));
  a_r6_nonempty: assert property (@(posedge clk) disable iff (rst)
    iv_valid |-> rptr != wp);
endmodule

// File: tb/ivring_consumer_test.sv
`timescale 1ns/1ps
module ivring_consumer_test;
  localparam int RB = 256;
  localparam int NSLOT = RB / 16;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick = 1'b0;
  logic [31:0] wptr_word = 32'd0;
  logic ovf_clr, mem_rd_en;
  logic [5:0] mem_rd_addr;
  logic [31:0] mem_rd_data = 32'd0;
  logic credit_req, credit_ack = 1'b0, credit_ok = 1'b0;
  logic [15:0] credit_pasid;
  logic iv_valid, iv_ready = 1'b0;
  logic [7:0] iv_client, iv_src_id, iv_ring_id, iv_vmid;
  logic [27:0] iv_src_data;
  logic [15:0] iv_pasid;
  logic db_wr, shadow_wr, reg_wr;
  logic [31:0] rptr_out;

  always #4 clk = ~clk;

  ivring_consumer uut (
    .clk(clk), .rst(rst), .kick(kick), .wptr_word(wptr_word), .ovf_clr(ovf_clr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .credit_req(credit_req), .credit_pasid(credit_pasid), .credit_ack(credit_ack),
    .credit_ok(credit_ok), .iv_valid(iv_valid), .iv_ready(iv_ready),
    .iv_client(iv_client), .iv_src_id(iv_src_id), .iv_src_data(iv_src_data),
    .iv_ring_id(iv_ring_id), .iv_vmid(iv_vmid), .iv_pasid(iv_pasid),
    .db_wr(db_wr), .shadow_wr(shadow_wr), .reg_wr(reg_wr), .rptr_out(rptr_out)
  );

  logic [31:0] mem [0:RB/4-1];
  logic [31:0] e0 [0:63];
  logic [31:0] e1 [0:63];
  logic [31:0] e2 [0:63];
  int tests = 0, fails = 0, cycle = 0;
  int exp_n, got, exp_creq, creqs, pubs, ovfs, m_wr = 0;
  logic [31:0] last_pub, late_word;
  bit late_pending = 0, rdy_always = 0, cr_busy = 0, stalled = 0;
  int cr_wait = 0, stall_fixed = 0;
  bit pend_v = 0;
  logic [5:0] pend_a = 6'd0;
  logic [71:0] prev_fields;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit grant(logic [15:0] p);
    return (p % 3) != 0;
  endfunction

  task automatic step();
    bit r;
    @(negedge clk);
    cycle++;
    if (cycle >= WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycle, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    // memory with one-cycle latency (R2)
    if (pend_v) mem_rd_data = mem[pend_a];
    pend_v = mem_rd_en;
    pend_a = mem_rd_addr;
    if (mem_rd_en) chk(mem_rd_addr[1:0] != 2'd3, "R2", "word 3 never read", 32'(mem_rd_addr), 32'd0);
    // credit responder (R10)
    credit_ack = 1'b0;
    if (cr_busy) begin
      chk(credit_req == 1'b1, "R10", "request held", 32'(credit_req), 32'd1);
      if (cr_wait == 0) begin
        credit_ack = 1'b1;
        credit_ok = grant(credit_pasid);
        cr_busy = 0;
      end else cr_wait--;
    end else if (credit_req) begin
      creqs++;
      chk(credit_pasid != 16'd0, "R3", "request pasid nonzero", 32'(credit_pasid), 32'd1);
      cr_busy = 1;
      cr_wait = (stall_fixed != 0) ? stall_fixed : int'($urandom % 7);
    end
    // stream hold check (R9)
    if (stalled)
      chk(iv_valid && {iv_src_id, iv_src_data, iv_ring_id, iv_vmid, iv_pasid} == prev_fields,
          "R9", "stalled vector stable", 32'(iv_valid), 32'd1);
    r = rdy_always ? 1'b1 : 1'($urandom % 2);
    iv_ready = r;
    stalled = iv_valid && !r;
    prev_fields = {iv_src_id, iv_src_data, iv_ring_id, iv_vmid, iv_pasid};
    if (iv_valid && r) begin
      if (got < exp_n) begin
        chk(iv_client == 8'd0, "R1", "client", 32'(iv_client), 32'd0);
        chk(iv_src_id == e0[got][7:0], "R1", "source id", 32'(iv_src_id), 32'(e0[got][7:0]));
        chk(iv_src_data == e1[got][27:0], "R1,R2", "source data", 32'(iv_src_data), 32'(e1[got][27:0]));
        chk(iv_ring_id == e2[got][7:0], "R1", "ring id", 32'(iv_ring_id), 32'(e2[got][7:0]));
        chk(iv_vmid == e2[got][15:8], "R1", "vmid", 32'(iv_vmid), 32'(e2[got][15:8]));
        chk(iv_pasid == e2[got][31:16], "R1", "pasid", 32'(iv_pasid), 32'(e2[got][31:16]));
      end else chk(1'b0, "R4", "unexpected vector", 32'(got), 32'(exp_n));
      got++;
    end
    // publish (R8) and late producer update (R6)
    if (db_wr || shadow_wr || reg_wr) begin
      chk(db_wr && shadow_wr && !reg_wr, "R8", "strobe pairing",
          {29'd0, db_wr, shadow_wr, reg_wr}, 32'd6);
      pubs++;
      last_pub = rptr_out;
      if (late_pending) begin
        wptr_word = late_word;
        late_pending = 0;
      end
    end
    if (ovf_clr) begin
      ovfs++;
      wptr_word[0] = 1'b0;
    end
  endtask

  task automatic fill_slot(int slot, bit force_fault);
    logic [7:0] src;
    logic [15:0] pasid;
    int k = $urandom % 5;
    if (force_fault || k < 2) src = (k[0]) ? 8'd147 : 8'd146;
    else if (k == 2) src = 8'(148 + $urandom % 100);
    else src = 8'($urandom % 146);
    if (force_fault) pasid = 16'(1 + $urandom % 65535);
    else pasid = ($urandom % 3 == 0) ? 16'd0 : 16'($urandom);
    mem[4*slot]   = ($urandom & 32'hFFFF_FF00) | 32'(src);
    mem[4*slot+1] = $urandom;
    mem[4*slot+2] = {pasid, 16'($urandom)};
    mem[4*slot+3] = $urandom;
  endtask

  task automatic expect_slot(int slot);
    logic [31:0] a = mem[4*slot], c = mem[4*slot+2];
    bit fault = (a[7:0] == 8'd146) || (a[7:0] == 8'd147);
    if (fault && c[31:16] != 16'd0) begin
      exp_creq++;
      if (!grant(c[31:16])) return;   // R4: refused fault dropped
    end
    e0[exp_n] = a; e1[exp_n] = mem[4*slot+1]; e2[exp_n] = c;
    exp_n++;
  endtask

  task automatic clear_expect();
    exp_n = 0; got = 0; exp_creq = 0; creqs = 0; pubs = 0; ovfs = 0;
  endtask

  task automatic kick_and_wait(int exp_pubs, int exp_ovfs, logic [31:0] exp_ptr, string tag);
    kick = 1'b1;
    step();
    kick = 1'b0;
    for (int n = 0; n < 6000; n++) begin
      step();
      if (pubs >= exp_pubs && got >= exp_n) break;
    end
    repeat (30) step();
    $display("[TB] scenario %s done", tag);
    chk(got == exp_n, "R4", "forwarded count", 32'(got), 32'(exp_n));
    chk(creqs == exp_creq, "R3", "credit requests", 32'(creqs), 32'(exp_creq));
    chk(pubs == exp_pubs, "R6", "publish count", 32'(pubs), 32'(exp_pubs));
    chk(last_pub == exp_ptr, "R5", "published pointer", last_pub, exp_ptr);
    chk(ovfs == exp_ovfs, "R7", "overflow clears", 32'(ovfs), 32'(exp_ovfs));
  endtask

  task automatic run_batch(int n, bit force_fault, int late_n, int stall, bit rdy, string tag);
    clear_expect();
    stall_fixed = stall;
    rdy_always = rdy;
    for (int i = 0; i < n; i++) begin
      fill_slot(((m_wr >> 4) + i) % NSLOT, force_fault);
      expect_slot(((m_wr >> 4) + i) % NSLOT);
    end
    m_wr = (m_wr + 16 * n) % RB;
    // R12: garbage above the ring-size bits must be ignored
    wptr_word = ($urandom & 32'hFFFF_FF00) | 32'(m_wr);
    if (late_n > 0) begin
      for (int i = 0; i < late_n; i++) begin
        fill_slot(((m_wr >> 4) + i) % NSLOT, 1'b0);
        expect_slot(((m_wr >> 4) + i) % NSLOT);
      end
      m_wr = (m_wr + 16 * late_n) % RB;
      late_word = ($urandom & 32'hFFFF_FF00) | 32'(m_wr);
      late_pending = 1;
    end
    kick_and_wait((late_n > 0) ? 2 : 1, 0, 32'(m_wr), tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < RB/4; i++) mem[i] = 32'd0;
    repeat (3) step();
    chk(!iv_valid && !credit_req && !mem_rd_en && !db_wr && !shadow_wr && !reg_wr && !ovf_clr,
        "R11", "strobes in reset", 32'(iv_valid), 32'd0);
    rst = 1'b0;
    step();
    chk(!iv_valid && !credit_req && !mem_rd_en && !db_wr && !ovf_clr,
        "R11", "strobes after reset", 32'(mem_rd_en), 32'd0);
    chk(rptr_out == 32'd0, "R11", "published pointer after reset", rptr_out, 32'd0);

    run_batch(6, 0, 0, 0, 0, "basic");               // R1 R3 R4 R5 R12
    run_batch(10, 0, 0, 0, 0, "wrap");               // R5 wrap past ring end
    run_batch(3, 0, 4, 0, 0, "late");                // R6 refetch finds late entries
    clear_expect();
    wptr_word = ($urandom & 32'hFFFF_FF00) | 32'(m_wr);
    kick_and_wait(1, 0, 32'(m_wr), "empty");         // R6 empty ring still publishes once
    run_batch(4, 1, 0, 60, 1, "long_stall");         // R10 long credit stall
    begin : overflow_case                            // R7
      int x;
      clear_expect();
      rdy_always = 0;
      stall_fixed = 0;
      x = ((m_wr >> 4) + 5) % NSLOT;
      for (int s = 0; s < NSLOT; s++) fill_slot(s, 1'b0);
      for (int k = 1; k < NSLOT; k++) expect_slot((x + k) % NSLOT);
      wptr_word = ($urandom & 32'hFFFF_FF00) | 32'(x * 16) | 32'd1;
      m_wr = x * 16;
      kick_and_wait(1, 1, 32'(m_wr), "overflow");
    end
    for (int b = 0; b < 5; b++)
      run_batch(1 + int'($urandom % 8), 0, 0, 0, ($urandom % 2) == 0, "random");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule